// File: doc/BRIEF.md
# Configuration Window Decoder

This block holds the 64-bit base-address register that places the memory-mapped PCI Express configuration window inside a host bridge. Software reaches the register through 32-bit configuration writes that carry a dword index and per-byte enables. Each write that touches either dword of the register recomputes the applied window from the new contents: an enable, a base address, and a length of 256 MiB, 128 MiB or 64 MiB. How many low base bits survive depends on the chosen length.

A lookup stream compares system addresses against the applied window and returns one hit or miss result per address. If a write selects the reserved length code, the block stores the bits but keeps the window that was applied before, and it raises an error pulse. Configuration writes are never back-pressured. Lookups follow valid/ready rules: a lookup is accepted when `lk_valid` and `lk_ready` are both high. A result stays on `res_hit` with `res_valid` high until `res_ready` is seen high.

Top module: `cfgwin_decoder`

## Requirements
- R1: After reset the register holds `RESET_VAL` (default 0x00000000_B0000000). The applied window is then disabled, with base 0xB0000000 and length 0x10000000, and `cfg_err` is low.
- R2: Register bit 0 enables the window. While the applied enable is 0, every lookup returns a miss.
- R3: Register bits 2:1 select the length. 00 gives 256 MiB, 01 gives 128 MiB and 10 gives 64 MiB. `win_len` shows the length in bytes.
- R4: The applied base is register bits 35:0 with every bit below the length boundary cleared. 256 MiB keeps bits 35:28, 128 MiB also keeps bit 27, and 64 MiB also keeps bits 27:26.
- R5: A touching write that leaves length code 11 in the register pulses `cfg_err` high for exactly one cycle, in the cycle after the write. Enable, base and length keep their previous applied values.
- R6: A write to any other dword index, or a write with all byte enables clear, leaves the window unchanged and raises no error.
- R7: Only the enabled bytes of a write change the register. Bytes that are not enabled keep their old contents and take part in the recomputation.
- R8: The low dword sits at index `REG_IDX` and the high dword (bits 35:32 of the base) at `REG_IDX+1`. A write to either dword recomputes the window from the whole 64-bit register, and a write to the high dword while code 11 is stored raises the error again.
- R9: The window outputs and `cfg_err` change at the clock edge that accepts the write. A lookup accepted at that same edge is judged against the window that was in force before the edge.
- R10: A lookup hits when the enable is set and base <= address <= base + length - 1. The result appears with `res_valid` one cycle after acceptance.
- R11: `lk_ready` equals `!res_valid || res_ready`. While `res_valid` is high and `res_ready` is low, `res_hit` holds steady. `wr_ready` is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Configuration write strobe |
| wr_ready | output | 1 | Write acceptance, always high |
| wr_idx | input | CFG_IDX_W | Dword index of the write |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte enables of the write |
| lk_valid | input | 1 | Lookup address valid |
| lk_ready | output | 1 | Lookup can be taken |
| lk_addr | input | ADDR_W | Address to compare |
| res_valid | output | 1 | Lookup result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_hit | output | 1 | Address lay inside the window |
| win_en | output | 1 | Applied window enable |
| win_base | output | ADDR_W | Applied window base |
| win_len | output | ADDR_W | Applied window length in bytes |
| cfg_err | output | 1 | One-cycle pulse on a reserved length |

## Verification
A register write and a lookup can be accepted at the same clock edge. The bench drives both in one cycle, for example enabling the window while asking about an address inside it. It expects a miss, because the lookup must see the window from before the edge, and it expects a hit on the next lookup. A second overlap comes from a reserved-code write that lands next to pending lookups. There the scoreboard expects lookup results taken from the unchanged earlier window, along with a one-cycle error pulse.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
  typedef enum logic [1:0] {
    WLEN_FULL = 2'b00,
    WLEN_HALF = 2'b01,
    WLEN_QTR  = 2'b10,
    WLEN_RSVD = 2'b11
  } wlen_e;

  localparam int REG_DWORDS = 2;
  localparam int DW_BYTES   = 4;
endpackage

// File: rtl/cfgwin_reg.sv
module cfgwin_reg
  import cfgwin_pkg::*;
#(
  parameter int          CFG_IDX_W = 6,
  parameter int          REG_IDX   = 24,
  parameter logic [63:0] RESET_VAL = 64'h0000_0000_B000_0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_fire,
  input  logic [CFG_IDX_W-1:0] wr_idx,
  input  logic [31:0]          wr_data,
  input  logic [3:0]           wr_be,
  output logic [63:0]          reg_nxt,
  output logic                 touch
);
  logic [63:0]           reg_q;
  logic [REG_DWORDS-1:0] dw_touch;

  for (genvar d = 0; d < REG_DWORDS; d++) begin : g_dw
    logic sel;
    assign sel         = wr_fire && (wr_idx == CFG_IDX_W'(REG_IDX + d));
    assign dw_touch[d] = sel && (|wr_be);
    for (genvar b = 0; b < DW_BYTES; b++) begin : g_byte
      assign reg_nxt[d*32 + b*8 +: 8] =
        (sel && wr_be[b]) ? wr_data[b*8 +: 8] : reg_q[d*32 + b*8 +: 8];
    end
  end

  assign touch = |dw_touch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_q <= RESET_VAL;
    else        reg_q <= reg_nxt;
  end
endmodule

// File: rtl/cfgwin_apply.sv
module cfgwin_apply
  import cfgwin_pkg::*;
#(
  parameter int          ADDR_W       = 36,
  parameter int          LEN_MAX_LOG2 = 28,
  parameter logic [63:0] RESET_VAL    = 64'h0000_0000_B000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              touch,
  input  logic [63:0]       reg_nxt,
  output logic              win_en,
  output logic [ADDR_W-1:0] win_base,
  output logic [ADDR_W-1:0] win_len,
  output logic              cfg_err
);
  function automatic logic [ADDR_W-1:0] span_of(input logic [1:0] code);
    case (code)
      WLEN_FULL: return ADDR_W'(1) << LEN_MAX_LOG2;
      WLEN_HALF: return ADDR_W'(1) << (LEN_MAX_LOG2 - 1);
      default:   return ADDR_W'(1) << (LEN_MAX_LOG2 - 2);
    endcase
  endfunction

  localparam logic [ADDR_W-1:0] RST_LEN  = span_of(RESET_VAL[2:1]);
  localparam logic [ADDR_W-1:0] RST_BASE = RESET_VAL[ADDR_W-1:0] & ~(RST_LEN - ADDR_W'(1));

  wlen_e             code;
  logic [ADDR_W-1:0] cand_len;
  logic [ADDR_W-1:0] cand_base;
  logic              reserved;
  logic              unused_hi;

  assign code      = wlen_e'(reg_nxt[2:1]);
  assign reserved  = (code == WLEN_RSVD);
  assign cand_len  = span_of(reg_nxt[2:1]);
  assign cand_base = reg_nxt[ADDR_W-1:0] & ~(cand_len - ADDR_W'(1));
  assign unused_hi = ^reg_nxt[63:ADDR_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_en   <= RESET_VAL[0];
      win_base <= RST_BASE;
      win_len  <= RST_LEN;
      cfg_err  <= 1'b0;
    end else begin
      cfg_err <= touch && reserved;
      if (touch && !reserved) begin
        win_en   <= reg_nxt[0];
        win_base <= cand_base;
        win_len  <= cand_len;
      end
    end
  end
endmodule

// File: rtl/cfgwin_match.sv
module cfgwin_match #(
  parameter int ADDR_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_hit,
  input  logic              win_en,
  input  logic [ADDR_W-1:0] win_base,
  input  logic [ADDR_W-1:0] win_len
);
  logic [ADDR_W:0] end_excl;
  logic            in_range;

  assign end_excl = {1'b0, win_base} + {1'b0, win_len};
  assign in_range = win_en && (lk_addr >= win_base) && ({1'b0, lk_addr} < end_excl);
  assign lk_ready = !res_valid || res_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
    end else if (lk_ready) begin
      res_valid <= lk_valid;
      if (lk_valid) res_hit <= in_range;
    end
  end
endmodule

// File: rtl/cfgwin_decoder.sv
module cfgwin_decoder #(
  parameter int          ADDR_W       = 36,
  parameter int          CFG_IDX_W    = 6,
  parameter int          REG_IDX      = 24,
  parameter int          LEN_MAX_LOG2 = 28,
  parameter logic [63:0] RESET_VAL    = 64'h0000_0000_B000_0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [CFG_IDX_W-1:0] wr_idx,
  input  logic [31:0]          wr_data,
  input  logic [3:0]           wr_be,
  input  logic                 lk_valid,
  output logic                 lk_ready,
  input  logic [ADDR_W-1:0]    lk_addr,
  output logic                 res_valid,
  input  logic                 res_ready,
  output logic                 res_hit,
  output logic                 win_en,
  output logic [ADDR_W-1:0]    win_base,
  output logic [ADDR_W-1:0]    win_len,
  output logic                 cfg_err
);
  logic [63:0] reg_nxt;
  logic        touch;

  assign wr_ready = 1'b1;

  cfgwin_reg #(
    .CFG_IDX_W(CFG_IDX_W), .REG_IDX(REG_IDX), .RESET_VAL(RESET_VAL)
  ) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_valid), .wr_idx(wr_idx),
    .wr_data(wr_data), .wr_be(wr_be), .reg_nxt(reg_nxt), .touch(touch)
  );

  cfgwin_apply #(
    .ADDR_W(ADDR_W), .LEN_MAX_LOG2(LEN_MAX_LOG2), .RESET_VAL(RESET_VAL)
  ) u_apply (
    .clk(clk), .rst_n(rst_n), .touch(touch), .reg_nxt(reg_nxt),
    .win_en(win_en), .win_base(win_base), .win_len(win_len), .cfg_err(cfg_err)
  );

  cfgwin_match #(.ADDR_W(ADDR_W)) u_match (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_addr(lk_addr), .res_valid(res_valid), .res_ready(res_ready),
    .res_hit(res_hit), .win_en(win_en), .win_base(win_base), .win_len(win_len)
  );
endmodule

// File: rtl/cfgwin_checker.sv
module cfgwin_checker #(
  parameter int ADDR_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              lk_valid,
  input logic              lk_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic              res_hit,
  input logic              win_en,
  input logic [ADDR_W-1:0] win_base,
  input logic [ADDR_W-1:0] win_len,
  input logic              cfg_err
);
  // R2: a lookup taken while disabled returns a miss
  a_r2_off_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready && !win_en) |=> !res_hit);

  // R3: the applied length is always a single power of two
  a_r3_len_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(win_len) == 1);

  // R4: the base is aligned to the applied length
  a_r4_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (win_base & (win_len - ADDR_W'(1))) == '0);

  // R5: an error pulse comes with an unchanged window
  a_r5_err_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> ($stable(win_en) && $stable(win_base) && $stable(win_len)));

  // R5: the error is a single-cycle pulse only after a write
  a_r5_err_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> !cfg_err);

  // R6: without a write the window stays put
  a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> ($stable(win_en) && $stable(win_base) && $stable(win_len)));

  // R11: a stalled result holds
  a_r11_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_hit)));
endmodule

bind cfgwin_decoder cfgwin_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .lk_valid(lk_valid),
  .lk_ready(lk_ready), .res_valid(res_valid), .res_ready(res_ready),
  .res_hit(res_hit), .win_en(win_en), .win_base(win_base),
  .win_len(win_len), .cfg_err(cfg_err)
);

// File: tb/cfgwin_decoder_test.sv
module cfgwin_decoder_test;
  localparam int AW  = 36;
  localparam int IW  = 6;
  localparam int RIX = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [IW-1:0] wr_idx = '0;
  logic [31:0]   wr_data = '0;
  logic [3:0]    wr_be = '0;
  logic          lk_valid = 1'b0;
  logic          lk_ready;
  logic [AW-1:0] lk_addr = '0;
  logic          res_valid;
  logic          res_ready = 1'b1;
  logic          res_hit;
  logic          win_en;
  logic [AW-1:0] win_base;
  logic [AW-1:0] win_len;
  logic          cfg_err;

  int n_tests = 0;
  int n_fail  = 0;

  logic [63:0]   m_reg = 64'h0000_0000_B000_0000;
  logic          m_en = 1'b0;
  logic [AW-1:0] m_base = 36'h0_B000_0000;
  logic [AW-1:0] m_len = 36'h0_1000_0000;
  logic          m_err = 1'b0;

  logic  exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  cfgwin_decoder uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_idx(wr_idx), .wr_data(wr_data), .wr_be(wr_be), .lk_valid(lk_valid),
    .lk_ready(lk_ready), .lk_addr(lk_addr), .res_valid(res_valid),
    .res_ready(res_ready), .res_hit(res_hit), .win_en(win_en),
    .win_base(win_base), .win_len(win_len), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic exp_hit(input logic [AW-1:0] a);
    return m_en && ({1'b0, a} >= {1'b0, m_base}) &&
           ({1'b0, a} <= ({1'b0, m_base} + {1'b0, m_len} - 37'd1));
  endfunction

  // reference recomputation from the requirement text (R3, R4, R5, R8)
  task automatic model_write(input logic [IW-1:0] idx, input logic [31:0] d, input logic [3:0] be);
    logic hit_dw;
    int   lg;
    hit_dw = 1'b0;
    for (int dw = 0; dw < 2; dw++) begin
      if (idx == IW'(RIX + dw)) begin
        for (int b = 0; b < 4; b++)
          if (be[b]) m_reg[dw*32 + b*8 +: 8] = d[b*8 +: 8];
        if (be != 4'b0) hit_dw = 1'b1;
      end
    end
    m_err = 1'b0;
    if (hit_dw) begin
      if (m_reg[2:1] == 2'b11) m_err = 1'b1;
      else begin
        lg     = 28 - int'(m_reg[2:1]);
        m_en   = m_reg[0];
        m_len  = AW'(1) << lg;
        m_base = m_reg[AW-1:0] & ~(m_len - AW'(1));
      end
    end
  endtask

  task automatic check_window(input string req);
    chk({req, " en"}, 64'(win_en), 64'(m_en));
    chk({req, " base"}, 64'(win_base), 64'(m_base));
    chk({req, " len"}, 64'(win_len), 64'(m_len));
    chk({req, " err"}, 64'(cfg_err), 64'(m_err));
  endtask

  task automatic cfg_write(input logic [IW-1:0] idx, input logic [31:0] d,
                           input logic [3:0] be, input string req);
    @(negedge clk);
    wr_valid = 1'b1; wr_idx = idx; wr_data = d; wr_be = be;
    model_write(idx, d, be);
    @(negedge clk);
    wr_valid = 1'b0; wr_be = '0;
    check_window(req);
  endtask

  task automatic lookup(input logic [AW-1:0] a, input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    exp_q.push_back(exp_hit(a)); tag_q.push_back(req);
    while (!lk_ready) @(negedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  // R9: write and lookup accepted at the same edge
  task automatic write_and_lookup(input logic [31:0] d, input logic [AW-1:0] a, input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    exp_q.push_back(exp_hit(a)); tag_q.push_back(req);
    wr_valid = 1'b1; wr_idx = IW'(RIX); wr_data = d; wr_be = 4'hF;
    model_write(IW'(RIX), d, 4'hF);
    @(negedge clk);
    lk_valid = 1'b0; wr_valid = 1'b0; wr_be = '0;
    check_window(req);
  endtask

  // scoreboard monitor: compares at the negedge before the consuming edge
  always @(negedge clk) begin
    if (rst_n && res_valid && res_ready) begin
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R10: unexpected result actual %0b expected none", res_hit);
      end else begin
        chk({tag_q.pop_front(), " hit"}, 64'(res_hit), 64'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_window("R1 reset");
    chk("R11 wr_ready", 64'(wr_ready), 64'd1);

    lookup(36'h0_B000_0000, "R2 disabled at base");

    cfg_write(IW'(RIX), 32'hE000_0001, 4'hF, "R3 256M");
    lookup(36'h0_E000_0000, "R10 low edge");
    lookup(36'h0_EFFF_FFFF, "R10 high edge");
    lookup(36'h0_F000_0000, "R10 above");
    lookup(36'h0_DFFF_FFFF, "R10 below");

    cfg_write(IW'(RIX), 32'hE800_0003, 4'hF, "R4 128M keeps bit27");
    lookup(36'h0_EFFF_FFFF, "R10 128M above");
    lookup(36'h0_E800_0000, "R10 128M base");
    cfg_write(IW'(RIX), 32'hE800_0001, 4'hF, "R4 256M drops bit27");
    cfg_write(IW'(RIX), 32'hEC00_0005, 4'hF, "R4 64M keeps bits27:26");
    lookup(36'h0_EFFF_FFFF, "R10 64M top");
    lookup(36'h0_F000_0000, "R10 64M past");
    lookup(36'h0_EBFF_FFFF, "R10 64M under");

    cfg_write(IW'(RIX), 32'h4000_0007, 4'hF, "R5 reserved");
    lookup(36'h0_EC00_0000, "R5 old window kept");
    chk("R5 pulse falls", 64'(cfg_err), 64'd0);

    cfg_write(IW'(RIX + 1), 32'h0000_0008, 4'h1, "R8 high dword while reserved");
    cfg_write(IW'(RIX), 32'h0000_0001, 4'h1, "R7 byte0 only");
    lookup(36'h8_4000_0000, "R8 high base bits");
    lookup(36'h0_4000_0000, "R8 high bits compared");

    cfg_write(IW'(RIX), 32'hFFFF_FF00, 4'h1, "R7 disable via byte0");
    lookup(36'h8_4000_0000, "R2 disabled miss");

    cfg_write(IW'(RIX + 2), 32'hFFFF_FFFF, 4'hF, "R6 other index above");
    cfg_write(IW'(RIX - 1), 32'hFFFF_FFFF, 4'hF, "R6 other index below");
    cfg_write(IW'(RIX), 32'h0000_0007, 4'h0, "R6 empty byte enables");

    write_and_lookup(32'h4000_0001, 36'h8_4000_0000, "R9 same edge sees old");
    lookup(36'h8_4000_0000, "R9 next lookup sees new");

    // R11 back-pressure
    @(posedge clk); #1 res_ready = 1'b0;
    lookup(36'h8_4FFF_FFFF, "R11 held result");
    repeat (3) @(negedge clk);
    chk("R11 valid held", 64'(res_valid), 64'd1);
    chk("R11 lk_ready low", 64'(lk_ready), 64'd0);
    chk("R11 hit held", 64'(res_hit), 64'd1);
    @(posedge clk); #1 res_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 drained", 64'(exp_q.size()), 64'd0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule